// File: doc/BRIEF.md
# Stepwise I2C Bus Master

This block is an I2C bus master that software drives one bus step at a time. It has four byte-wide registers: control, status, data and clock divider. Software requests each step (START, one byte, or STOP) by writing the control register. The master carries out only that step. It then raises a completion flag and posts a status code that describes the outcome. Until software clears the flag again, nothing further happens on the bus.

A single-byte write runs as four steps, with a status check after each one: START, then the slave address with the write bit, then the data byte, then STOP. The data register holds whichever byte goes out next, address or data. The first byte after a START (or a repeated START) is reported as an address byte, and later bytes are reported as data bytes. Both lines are open-drain. The block only ever pulls SCL or SDA low, and it senses SDA to read the slave's acknowledge bit. The SCL rate comes from the divider register.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0xF8, the data register reads 0x00 and the divider reads DIV_RESET (4). Neither SCL nor SDA is pulled low.
- R2: A write to the control register (offset 0) with bit 7 at zero starts no bus activity and leaves the completion flag (bit 7) unchanged.
- R3: A write to the control register with bit 7 at one, made while no step is running, does three things. It clears the completion flag, sets the status to 0xF8 and starts one step. The step is START if bit 5 is one, STOP if bit 5 is zero and bit 4 is one, and otherwise a byte. While a step is running, control bit 0 reads one.
- R4: A START step releases SDA and SCL, then drives SDA low while SCL is high, then drives SCL low. It finishes with the completion flag set and status 0x08.
- R5: A byte step shifts out the data register (offset 2) MSB first, one bit per SCL pulse, and then releases SDA for a ninth acknowledge pulse. It ends with SCL held low and the completion flag set. Status is 0x18 or 0x20 for the first byte after a START, and 0x28 or 0x30 for any later byte.
- R6: The acknowledge level is sampled while SCL is high on the ninth pulse. A low level gives the ACK code (0x18 or 0x28), and a high level gives the NACK code (0x20 or 0x30).
- R7: A STOP step drives SCL low and then SDA low, releases SCL, and then releases SDA while SCL is high. Afterwards the block is idle, the completion flag stays clear and the status is 0xF8.
- R8: SDA changes level while SCL is released only during a START or STOP step.
- R9: Each quarter of an SCL bit lasts divider+1 clock cycles, so SCL rising edges within a byte are 4×(divider+1) cycles apart. The divider is at offset 3.
- R10: While a step is running, writes to the control, data and divider registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 data, 3 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The bench models a slave that can acknowledge or refuse each byte, so both acknowledge codes are exercised for address bytes and for data bytes. A design that sampled the acknowledge bit in the wrong phase would report the opposite code. A repeated START followed by a byte checks that the address and data codes are told apart correctly; a design that only tracked the very first byte of a transfer would post 0x28 where 0x18 belongs. The bench writes the data and control registers in the middle of a running step. This catches a design that corrupts the outgoing byte or launches a stray START, because the bus monitor would see an unexpected event. Finally, the bench measures the SCL period at two divider settings and checks that a STOP never sets the completion flag.

// File: rtl/i2c_step_pkg.sv
// Shared definitions for the stepwise I2C master: step kinds, status
// codes, register offsets and control bit positions.
package i2c_step_pkg;

    typedef enum logic [1:0] {
        STEP_NONE  = 2'd0,
        STEP_START = 2'd1,
        STEP_BYTE  = 2'd2,
        STEP_STOP  = 2'd3
    } step_e;

    localparam logic [7:0] ST_START     = 8'h08;
    localparam logic [7:0] ST_ADDR_ACK  = 8'h18;
    localparam logic [7:0] ST_ADDR_NACK = 8'h20;
    localparam logic [7:0] ST_DATA_ACK  = 8'h28;
    localparam logic [7:0] ST_DATA_NACK = 8'h30;
    localparam logic [7:0] ST_IDLE      = 8'hF8;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_DIV  = 2'd3;

    localparam int CB_DONE  = 7;
    localparam int CB_START = 5;
    localparam int CB_STOP  = 4;
    localparam int CB_BUSY  = 0;

endpackage

// File: rtl/i2c_step_tick.sv
// Quarter-bit timebase. While run is high, tick pulses once every div+1
// clock cycles; when run is low the count is held at zero so that each
// step starts with a full first quarter.
// Assumes div is stable while run is high.
module i2c_step_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count quarter periods and emit a one-cycle tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R9: with a nonzero divider, ticks are never back to back
    assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && div != '0) |=> !tick);

endmodule

// File: rtl/i2c_step_engine.sv
// Bit-level bus sequencer. It executes one step (START, byte or STOP)
// per launch, advancing one quarter phase per tick, and reports its end
// with a one-cycle done pulse.
// Assumes launch is only honoured while idle and that SDA is an
// asynchronous input (it is synchronised here). No clock stretching.
module i2c_step_engine
    import i2c_step_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  step_e             launch_step,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              sda_in,
    output logic              busy,
    output logic              done,
    output step_e             done_step,
    output logic              nack,
    output logic              scl_oe,
    output logic              sda_oe
);

    localparam int ACK_IDX  = BYTE_W;
    localparam int TAIL_IDX = BYTE_W + 1;
    localparam int IDX_W    = $clog2(TAIL_IDX + 1);

    step_e             cur_step;
    logic [1:0]        phase;
    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic [1:0]        sda_sync;

    assign done_step = cur_step;

    // Two-stage synchroniser for the sensed SDA level.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_sync <= 2'b11;
        else        sda_sync <= {sda_sync[0], sda_in};
    end

    // Step sequencer: load on launch, then act on each quarter-phase tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cur_step <= STEP_NONE;
            phase    <= 2'd0;
            bit_idx  <= '0;
            shreg    <= '0;
            nack     <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch && !busy) begin
                busy     <= 1'b1;
                cur_step <= launch_step;
                phase    <= 2'd0;
                bit_idx  <= '0;
                shreg    <= tx_byte;
                nack     <= 1'b0;
            end else if (busy && tick) begin
                phase <= phase + 2'd1;
                unique case (cur_step)
                    STEP_START: begin
                        unique case (phase)
                            2'd0: sda_oe <= 1'b0;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b1;
                            2'd3: begin
                                scl_oe <= 1'b1;
                                busy   <= 1'b0;
                                done   <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    STEP_BYTE: begin
                        unique case (phase)
                            2'd0: begin
                                scl_oe <= 1'b1;
                                if (bit_idx == IDX_W'(TAIL_IDX)) begin
                                    busy <= 1'b0;
                                    done <= 1'b1;
                                end
                            end
                            2'd1: sda_oe <= (bit_idx == IDX_W'(ACK_IDX)) ? 1'b0
                                                                         : ~shreg[BYTE_W-1];
                            2'd2: scl_oe <= 1'b0;
                            2'd3: begin
                                if (bit_idx == IDX_W'(ACK_IDX)) nack <= sda_sync[1];
                                else shreg <= {shreg[BYTE_W-2:0], 1'b0};
                                bit_idx <= bit_idx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    STEP_STOP: begin
                        unique case (phase)
                            2'd0: scl_oe <= 1'b1;
                            2'd1: sda_oe <= 1'b1;
                            2'd2: scl_oe <= 1'b0;
                            2'd3: begin
                                sda_oe <= 1'b0;
                                busy   <= 1'b0;
                                done   <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    default: begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R8: SDA only moves under a released SCL while forming START or STOP
    assert_sda_steady_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(scl_oe)) |->
            (cur_step == STEP_START || cur_step == STEP_STOP));

    // R5: a finished byte step leaves SCL held low
    assert_byte_ends_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_step == STEP_BYTE) |-> scl_oe);

    // R7: a finished STOP leaves both lines released
    assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_step == STEP_STOP) |-> (!scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_step_regs.sv
// Software-facing register file: control (completion flag, step
// request bits, busy), status code, shared address/data byte and SCL
// divider. Decodes step launches and posts the result of each step.
// Assumes single-cycle write strobes; reads are combinational.
module i2c_step_regs
    import i2c_step_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  step_e            eng_step,
    input  logic             eng_nack,
    output logic             launch,
    output step_e            launch_step,
    output logic [7:0]       tx_byte,
    output logic [DIV_W-1:0] div
);

    logic       flag;
    logic [7:0] status;
    logic       addr_next;
    logic       idle_wr;

    assign idle_wr = wr && !eng_busy;
    assign launch  = idle_wr && (addr == RA_CTRL) && wdata[CB_DONE];

    // Pick the requested step from the request bits of the control write.
    always_comb begin
        if (wdata[CB_START])     launch_step = STEP_START;
        else if (wdata[CB_STOP]) launch_step = STEP_STOP;
        else                     launch_step = STEP_BYTE;
    end

    // Completion flag: cleared by a launching write, set when a non-STOP step ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (launch)                         flag <= 1'b0;
        else if (eng_done && eng_step != STEP_STOP) flag <= 1'b1;
    end

    // Status code and address/data tracking for byte steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status    <= ST_IDLE;
            addr_next <= 1'b0;
        end else if (launch) begin
            status <= ST_IDLE;
        end else if (eng_done) begin
            unique case (eng_step)
                STEP_START: begin
                    status    <= ST_START;
                    addr_next <= 1'b1;
                end
                STEP_BYTE: begin
                    if (addr_next) status <= eng_nack ? ST_ADDR_NACK : ST_ADDR_ACK;
                    else           status <= eng_nack ? ST_DATA_NACK : ST_DATA_ACK;
                    addr_next <= 1'b0;
                end
                default: begin
                    status    <= ST_IDLE;
                    addr_next <= 1'b0;
                end
            endcase
        end
    end

    // Data and divider registers, writable only between steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            div     <= DIV_W'(DIV_RESET);
        end else if (idle_wr) begin
            if (addr == RA_DATA) tx_byte <= wdata;
            if (addr == RA_DIV)  div     <= wdata[DIV_W-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_CTRL: begin
                rdata[CB_DONE] = flag;
                rdata[CB_BUSY] = eng_busy;
            end
            RA_STAT: rdata = status;
            RA_DATA: rdata = tx_byte;
            RA_DIV:  rdata = 8'(div);
            default: rdata = '0;
        endcase
    end

    // R3: no bus operation runs while the completion flag is set
    assert_flag_blocks_engine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> !eng_busy);

    // R2: a control write with bit 7 clear, made while idle, starts nothing
    assert_zero_write_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == RA_CTRL && !wdata[CB_DONE] && !eng_busy) |=> !eng_busy);

    // R7: a finished STOP never raises the completion flag
    assert_stop_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_step == STEP_STOP) |=> (!flag && status == ST_IDLE));

    // R4: a finished START posts its code
    assert_start_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_step == STEP_START) |=> (flag && status == ST_START));

    // R10: the data byte holds still while a step runs
    assert_data_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eng_busy) && eng_busy) |-> $stable(tx_byte));

endmodule

// File: rtl/i2c_step_master.sv
// Stepwise I2C bus master top level: register file, quarter-bit
// timebase and bus sequencer. Open-drain outputs pull the line low
// when asserted; the board supplies pull-ups.
// Assumes a single master on the bus and slaves that never stretch SCL.
module i2c_step_master #(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    import i2c_step_pkg::*;

    logic             launch;
    step_e            launch_step;
    logic [7:0]       tx_byte;
    logic [DIV_W-1:0] div;
    logic             tick;
    logic             eng_busy;
    logic             eng_done;
    step_e            eng_step;
    logic             eng_nack;

    i2c_step_regs #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .eng_step    (eng_step),
        .eng_nack    (eng_nack),
        .launch      (launch),
        .launch_step (launch_step),
        .tx_byte     (tx_byte),
        .div         (div)
    );

    i2c_step_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .div   (div),
        .tick  (tick)
    );

    i2c_step_engine #(
        .BYTE_W (8)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_step (launch_step),
        .tx_byte     (tx_byte),
        .tick        (tick),
        .sda_in      (sda_in),
        .busy        (eng_busy),
        .done        (eng_done),
        .done_step   (eng_step),
        .nack        (eng_nack),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

endmodule

// File: tb/i2c_step_master_tb.sv
module i2c_step_master_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       sda_in;
    logic       slave_pull = 1'b0;
    logic       slave_ack = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // Expected bus events: 'h100 START, 'h200 STOP, otherwise a byte value
    int exp_q[$];

    assign sda_in = ~(sda_oe | slave_pull);

    i2c_step_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .sda_in    (sda_in)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: decode bus events, model the slave, compare against the queue
    int  bitcnt = 0;
    int  shift = 0;
    int  rise_t = 0;
    int  last_period = 0;
    bit  p_scl = 1, p_sda = 1;

    task automatic pop_cmp(input int act, input string req);
        int e;
        if (exp_q.size() == 0) e = -1;
        else e = exp_q.pop_front();
        check(act == e, req, act, e);
    endtask

    always @(negedge clk) begin
        bit scl, sda;
        scl = ~scl_oe;
        sda = ~(sda_oe | slave_pull);
        if (rst_n) begin
            if (scl && p_scl && p_sda && !sda) begin
                pop_cmp('h100, "R4 bus START");
                bitcnt = 0;
                slave_pull = 1'b0;
            end else if (scl && p_scl && !p_sda && sda) begin
                pop_cmp('h200, "R7 bus STOP");
            end
            if (scl && !p_scl) begin
                bitcnt++;
                if (bitcnt <= 8) shift = ((shift << 1) | int'(sda)) & 'hFF;
                if (bitcnt == 1) rise_t = cyc;
                if (bitcnt == 2) last_period = cyc - rise_t;
                if (bitcnt == 8) pop_cmp(shift, "R5 bus byte");
            end
            if (!scl && p_scl) begin
                if (bitcnt == 8 && slave_ack) slave_pull = 1'b1;
                if (bitcnt == 9) begin
                    slave_pull = 1'b0;
                    bitcnt = 0;
                end
            end
            p_scl = ~scl_oe;
            p_sda = ~(sda_oe | slave_pull);
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_flag();
        logic [7:0] c;
        for (int i = 0; i < 20000; i++) begin
            rd_reg(2'd0, c);
            if (c[7]) break;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 20000; i++) begin
            rd_reg(2'd0, c);
            if (!c[0]) break;
        end
    endtask

    // Driver: push expected bus event, launch step, then check the status
    task automatic step(input logic [7:0] ctrl, input int ev, input logic [7:0] exp_st,
                        input string req);
        logic [7:0] v;
        exp_q.push_back(ev);
        wr_reg(2'd0, ctrl);
        wait_flag();
        rd_reg(2'd1, v);
        check(v == exp_st, req, v, exp_st);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
        rd_reg(2'd1, v); check(v == 8'hF8, "R1 status", v, 8'hF8);
        rd_reg(2'd2, v); check(v == 8'h00, "R1 data", v, 8'h00);
        rd_reg(2'd3, v); check(v == 8'h04, "R1 divider", v, 8'h04);
        check({scl_oe, sda_oe} == 2'b00, "R1 lines released", {scl_oe, sda_oe}, 0);

        // R2 control write with bit 7 clear does nothing
        wr_reg(2'd0, 8'h20);
        repeat (100) @(negedge clk);
        rd_reg(2'd0, v); check(v == 8'h00, "R2 no launch", v, 8'h00);
        check({scl_oe, sda_oe} == 2'b00, "R2 bus idle", {scl_oe, sda_oe}, 0);

        // Single-byte write, divider 4, slave acknowledges
        slave_ack = 1'b1;
        wr_reg(2'd2, 8'hA4);
        step(8'hA0, 'h100, 8'h08, "R4 START status");
        rd_reg(2'd0, v); check(v == 8'h80, "R3 flag set busy clear", v, 8'h80);
        step(8'h80, 'hA4, 8'h18, "R6 address ACK status");
        check(last_period == 20, "R9 period div4", last_period, 20);
        check(scl_oe == 1'b1, "R5 SCL held low", scl_oe, 1);

        // R2 write of zero leaves the set flag alone
        wr_reg(2'd0, 8'h00);
        rd_reg(2'd0, v); check(v == 8'h80, "R2 flag kept", v, 8'h80);

        // R10 writes during a running byte step are ignored
        wr_reg(2'd2, 8'h5B);
        exp_q.push_back('h5B);
        wr_reg(2'd0, 8'h80);
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd0, 8'hA0);
        wr_reg(2'd3, 8'h09);
        wait_flag();
        rd_reg(2'd1, v); check(v == 8'h28, "R5 data ACK status", v, 8'h28);
        rd_reg(2'd2, v); check(v == 8'h5B, "R10 data kept", v, 8'h5B);
        rd_reg(2'd3, v); check(v == 8'h04, "R10 divider kept", v, 8'h04);
        repeat (60) @(negedge clk);
        rd_reg(2'd0, v); check(v == 8'h80, "R10 no extra step", v, 8'h80);

        // R7 STOP
        exp_q.push_back('h200);
        wr_reg(2'd0, 8'h90);
        wait_idle();
        repeat (5) @(negedge clk);
        rd_reg(2'd0, v); check(v == 8'h00, "R7 flag stays clear", v, 8'h00);
        rd_reg(2'd1, v); check(v == 8'hF8, "R7 status idle", v, 8'hF8);
        check({scl_oe, sda_oe} == 2'b00, "R7 lines released", {scl_oe, sda_oe}, 0);

        // Divider 1, address refused, repeated START, data refused
        wr_reg(2'd3, 8'h01);
        slave_ack = 1'b0;
        wr_reg(2'd2, 8'h3C);
        step(8'hA0, 'h100, 8'h08, "R3 START via bit 5");
        step(8'h80, 'h3C, 8'h20, "R6 address NACK status");
        check(last_period == 8, "R9 period div1", last_period, 8);
        step(8'hB0, 'h100, 8'h08, "R3 START wins over STOP");
        slave_ack = 1'b1;
        wr_reg(2'd2, 8'h3D);
        step(8'h80, 'h3D, 8'h18, "R5 address after repeated START");
        slave_ack = 1'b0;
        wr_reg(2'd2, 8'hC3);
        step(8'h80, 'hC3, 8'h30, "R6 data NACK status");
        exp_q.push_back('h200);
        wr_reg(2'd0, 8'h90);
        wait_idle();
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8 all bus events seen", exp_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule